// File: doc/BRIEF.md
# Programmable Address Group Decoder

This block decides which of seven system resource groups a bus master's access falls into. The seven groups are:

- the lower DRAM bank pair;
- the upper DRAM bank pair;
- the first device chip-select group;
- the group made of the last chip select plus the boot select;
- the internal register space;
- PCI I/O;
- PCI memory.

Each group has a window with its own programmable base, size and enable. A size is a power of two from 2 MB to 256 MB. The block returns three things:

- a one-hot group select;
- the access offset inside the winning window, counted in 1 MB steps, for a shared device sub-decoder;
- an overlap flag when more than one window matched.

One instance sits in front of each master. The CPU instance decodes 36 address bits (64 GB). PCI instances are built with 32 address bits (4 GB). The DMA engine has no instance of its own and uses the CPU instance's mapping. When `REPORT_ERR` is set, as on the CPU instance, an access that matches no group behaves as follows:

- it captures the faulting address;
- it raises an interrupt for a read or a write;
- for a read only, it also pulses a bus-error indication.

The captured address stays frozen until software clears the interrupt.

Top module: `addr_group_decoder`

## Requirements
- R1: After reset every group is disabled, so any request misses, and all result outputs, `irq` and `err_addr` are zero.
- R2: A group matches when it is enabled and `req_addr` lies in [B, B+S). S = 2 MB << `cfg_size` and B is the programmed base with its low log2(S) bits cleared.
- R3: The result appears on the clock edge that follows a cycle with `req_valid` high. At that point `res_valid` is 1 and `grp_sel` is one-hot, with bit g for group g. On a miss `grp_sel` is all zero and `miss` is 1. With no request, `grp_sel`, `miss`, `overlap` and `bus_err` are 0.
- R4: When several groups match, the lowest-numbered one is selected and `overlap` is 1.
- R5: `mb_off` holds address bits [27:20] masked to the window size minus one, in MB. This is the 1 MB index inside the window, and it is 0 on a miss.
- R6: Base bits below the window size are ignored, and so are bits below 2 MB.
- R7: A missed read pulses `bus_err` together with the result. A missed write leaves `bus_err` at 0.
- R8: A miss of either kind sets `irq` and loads `err_addr` with the request address, provided `irq` was clear.
- R9: While `irq` is set, later misses leave `err_addr` unchanged. `irq_clr` clears `irq`, and a miss in that same cycle is captured.
- R10: Size code 0 gives a 2 MB window and code 7 gives a 256 MB window, with offsets up to 255.
- R11: A group written with `cfg_en`=0 never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write one group's window registers |
| cfg_grp | input | 3 | Group index 0..6 to write |
| cfg_en | input | 1 | Enable of the written group |
| cfg_base | input | ADDR_W | Window base (low bits ignored) |
| cfg_size | input | 3 | Size code, window = 2 MB << code |
| req_valid | input | 1 | Access address strobe |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_addr | input | ADDR_W | Access address |
| irq_clr | input | 1 | Clears the miss interrupt |
| res_valid | output | 1 | Decode result valid |
| grp_sel | output | 7 | One-hot group select, zero on miss |
| mb_off | output | 8 | 1 MB index within the window |
| miss | output | 1 | No group matched |
| overlap | output | 1 | More than one group matched |
| bus_err | output | 1 | Read miss indication |
| irq | output | 1 | Sticky miss interrupt |
| err_addr | output | ADDR_W | First faulting address |

## Verification
A corrupted base, size or enable register has a visible effect on the next request that falls near that window's edges. The bench therefore probes the first and last MB of every window and one address just past each window, so a window that is shifted, shrunk or grown shows up one cycle after the strobe as a wrong `grp_sel` or `mb_off`. A broken priority chain is exposed by the deliberate overlap, which gives the wrong one-hot bit on that same cycle. An error-capture register that lost its hold shows a changed `err_addr` right after a second miss.

// File: rtl/addr_group_decoder.sv
module addr_group_decoder #(
  parameter int ADDR_W     = 36,
  parameter bit REPORT_ERR = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_grp,
  input  logic              cfg_en,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [2:0]        cfg_size,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              irq_clr,
  output logic              res_valid,
  output logic [6:0]        grp_sel,
  output logic [7:0]        mb_off,
  output logic              miss,
  output logic              overlap,
  output logic              bus_err,
  output logic              irq,
  output logic [ADDR_W-1:0] err_addr
);
  localparam int GRP_N   = 7;
  localparam int WIN_LSB = 21;
  localparam int TAG_W   = ADDR_W - WIN_LSB;
  localparam int OFF_W   = 8;

  logic [TAG_W-1:0] base_q [GRP_N];
  logic [2:0]       size_q [GRP_N];
  logic [GRP_N-1:0] en_q;
  logic [GRP_N-1:0] hit;
  logic [GRP_N-1:0] win_sel;
  logic [OFF_W-1:0] win_off;
  logic             multi;
  logic             rd_miss_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
      for (int g = 0; g < GRP_N; g++) begin
        base_q[g] <= '0;
        size_q[g] <= '0;
      end
    end else if (cfg_we && cfg_grp < 3'(GRP_N)) begin
      en_q[cfg_grp]   <= cfg_en;
      base_q[cfg_grp] <= cfg_base[ADDR_W-1:WIN_LSB];
      size_q[cfg_grp] <= cfg_size;
    end
  end

  for (genvar g = 0; g < GRP_N; g++) begin : g_win
    wire [TAG_W-1:0] tag_mask = {TAG_W{1'b1}} << size_q[g];
    assign hit[g] = en_q[g] &&
      (((req_addr[ADDR_W-1:WIN_LSB] ^ base_q[g]) & tag_mask) == '0);
  end

  assign multi = (hit & (hit - 1'b1)) != '0;

  always_comb begin
    win_sel = '0;
    win_off = '0;
    for (int g = GRP_N - 1; g >= 0; g--) begin
      if (hit[g]) begin
        win_sel    = '0;
        win_sel[g] = 1'b1;
        win_off    = req_addr[WIN_LSB-1 +: OFF_W] &
                     OFF_W'((9'd2 << size_q[g]) - 9'd1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      grp_sel   <= '0;
      mb_off    <= '0;
      miss      <= 1'b0;
      overlap   <= 1'b0;
      rd_miss_q <= 1'b0;
    end else begin
      res_valid <= req_valid;
      grp_sel   <= req_valid ? win_sel : '0;
      mb_off    <= req_valid ? win_off : '0;
      miss      <= req_valid && (hit == '0);
      overlap   <= req_valid && multi;
      rd_miss_q <= req_valid && !req_write && (hit == '0);
    end
  end

  if (REPORT_ERR) begin : g_err
    logic [ADDR_W-1:0] err_q;
    logic              irq_q;
    wire               miss_now = req_valid && (hit == '0);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        irq_q <= 1'b0;
        err_q <= '0;
      end else begin
        if (irq_clr) irq_q <= 1'b0;
        if (miss_now && (!irq_q || irq_clr)) begin
          irq_q <= 1'b1;
          err_q <= req_addr;
        end
      end
    end
    assign irq      = irq_q;
    assign err_addr = err_q;
    assign bus_err  = rd_miss_q;

    assert_irq_on_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && miss) |-> irq);
    assert_err_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(irq) && !$past(irq_clr)) |-> $stable(err_addr));
  end else begin : g_noerr
    assign irq      = 1'b0;
    assign err_addr = '0;
    assign bus_err  = 1'b0;
  end

  assert_onehot_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grp_sel));
  assert_miss_vs_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (miss == (grp_sel == '0)));
  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (grp_sel == '0 && !miss && !overlap && !bus_err));
  assert_overlap_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    overlap |-> (res_valid && !miss));
  assert_buserr_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (res_valid && miss));
  assert_offset_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> (mb_off == '0));
endmodule

// File: tb/test_addr_group_decoder.sv
module test_addr_group_decoder;
  localparam int AW = 36;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_en = 0, req_valid = 0, req_write = 0, irq_clr = 0;
  logic [2:0] cfg_grp = 0, cfg_size = 0;
  logic [AW-1:0] cfg_base = '0, req_addr = '0;
  logic res_valid, miss, overlap, bus_err, irq;
  logic [6:0] grp_sel;
  logic [7:0] mb_off;
  logic [AW-1:0] err_addr;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  addr_group_decoder #(.ADDR_W(AW), .REPORT_ERR(1'b1)) i_addr_group_decoder (
    .clk, .rst_n, .cfg_we, .cfg_grp, .cfg_en, .cfg_base, .cfg_size,
    .req_valid, .req_write, .req_addr, .irq_clr, .res_valid, .grp_sel,
    .mb_off, .miss, .overlap, .bus_err, .irq, .err_addr);

  // {address, expected group (7 = miss), expected MB offset}
  localparam int NV = 15;
  localparam logic [46:0] VEC [NV] = '{
    {36'h0_0000_0000, 3'd0, 8'd0},
    {36'h0_00F0_0000, 3'd0, 8'd15},
    {36'h0_00FF_FFFF, 3'd0, 8'd15},
    {36'h0_0100_0000, 3'd1, 8'd0},
    {36'h0_01A3_0000, 3'd1, 8'd10},
    {36'h0_1C1F_FFFF, 3'd2, 8'd1},
    {36'h0_1C20_0000, 3'd7, 8'd0},
    {36'h0_1F3F_0000, 3'd3, 8'd3},
    {36'h0_1F40_0000, 3'd7, 8'd0},
    {36'h0_1400_0001, 3'd4, 8'd0},
    {36'h0_13FF_FFFF, 3'd5, 8'd63},
    {36'h8_0FFF_FFFF, 3'd6, 8'd255},
    {36'h8_1000_0000, 3'd7, 8'd0},
    {36'h0_8000_0000, 3'd7, 8'd0},
    {36'h1_0000_0000, 3'd7, 8'd0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(input int g, input bit en, input logic [AW-1:0] b, input int sz);
    @(negedge clk);
    cfg_we = 1; cfg_grp = 3'(g); cfg_en = en; cfg_base = b; cfg_size = 3'(sz);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic access(input logic [AW-1:0] a, input bit wr);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_write = wr;
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state and everything misses
    @(negedge clk);
    chk("R1 res_valid", 64'(res_valid), 0);
    chk("R1 irq", 64'(irq), 0);
    chk("R1 err_addr", 64'(err_addr), 0);
    access(36'h0_0000_0000, 1'b0);
    chk("R1 miss after reset", 64'(miss), 1);
    chk("R1 grp_sel after reset", 64'(grp_sel), 0);
    @(negedge clk); irq_clr = 1; @(negedge clk); irq_clr = 0;

    cfg(0, 1, 36'h0_0000_0000, 3);      // 16 MB
    cfg(1, 1, 36'h0_0100_0000, 3);      // 16 MB
    cfg(2, 1, 36'h0_1C0A_BCDE, 0);      // R6: low bits dropped, 2 MB
    cfg(3, 1, 36'h0_1F20_0000, 1);      // R6: 4 MB, bit 21 ignored
    cfg(4, 1, 36'h0_1400_0000, 0);      // 2 MB
    cfg(5, 1, 36'h0_1000_0000, 5);      // 64 MB
    cfg(6, 1, 36'h8_0000_0000, 7);      // R10: 256 MB

    // R2 R3 R5 R6 R7 R10: table walk, all reads
    for (int i = 0; i < NV; i++) begin
      logic [AW-1:0] a;
      logic [2:0] eg;
      logic [7:0] eo;
      {a, eg, eo} = VEC[i];
      access(a, 1'b0);
      chk($sformatf("R3 res_valid v%0d", i), 64'(res_valid), 1);
      chk($sformatf("R2 grp_sel v%0d", i), 64'(grp_sel), (eg == 3'd7) ? 64'd0 : 64'(7'd1 << eg));
      chk($sformatf("R5 mb_off v%0d", i), 64'(mb_off), 64'(eo));
      chk($sformatf("R3 miss v%0d", i), 64'(miss), 64'(eg == 3'd7));
      chk($sformatf("R7 bus_err v%0d", i), 64'(bus_err), 64'(eg == 3'd7));
      chk($sformatf("R4 no overlap v%0d", i), 64'(overlap), 0);
    end

    // R8 R9: first miss of the walk held
    chk("R8 irq after misses", 64'(irq), 1);
    chk("R9 err_addr holds first", 64'(err_addr), 64'(36'h0_1C20_0000));
    @(negedge clk);
    chk("R3 idle no result", 64'(res_valid), 0);
    chk("R3 idle grp_sel", 64'(grp_sel), 0);

    // R9: clear, then write miss captured, R7 no bus_err on write
    @(negedge clk); irq_clr = 1; @(negedge clk); irq_clr = 0;
    chk("R9 irq cleared", 64'(irq), 0);
    access(36'h0_9000_0000, 1'b1);
    chk("R7 write miss no bus_err", 64'(bus_err), 0);
    chk("R8 write miss irq", 64'(irq), 1);
    chk("R8 write miss addr", 64'(err_addr), 64'(36'h0_9000_0000));
    access(36'h0_A000_0000, 1'b0);
    chk("R9 second miss no overwrite", 64'(err_addr), 64'(36'h0_9000_0000));
    chk("R7 read miss bus_err", 64'(bus_err), 1);

    // R4: overlap, lowest group wins
    cfg(6, 1, 36'h0_0000_0000, 0);
    access(36'h0_0010_0000, 1'b0);
    chk("R4 lowest wins", 64'(grp_sel), 64'(7'b000_0001));
    chk("R4 overlap flag", 64'(overlap), 1);
    chk("R5 offset of winner", 64'(mb_off), 1);

    // R11: disabled group never matches
    cfg(0, 0, 36'h0_0000_0000, 3);
    access(36'h0_0010_0000, 1'b0);
    chk("R11 disabled skipped", 64'(grp_sel), 64'(7'b100_0000));
    chk("R11 overlap gone", 64'(overlap), 0);
    access(36'h0_0030_0000, 1'b0);
    chk("R11 disabled range misses", 64'(miss), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule